// File: doc/BRIEF.md
# Standby Mode Power Controller

This block decides when a small processor core may run and when it must rest. Software writes a four-bit clock control word. Two bits of that word ask for one of two standby levels. In the light level the processor clock is gated but the oscillator keeps running. In the deep level the oscillator is also switched off. The other two bits choose the processor clock rate. A new rate is applied only after a programmable switch-over delay. While that delay runs, a standby request waits.

An interrupt source whose request and enable are both set ends standby. Leaving the light level takes one cycle. Leaving the deep level first turns the oscillator back on and then holds the processor clock off for a settling window of 2^9 oscillator cycles.

A deep request made while a wake source is already present does not stop the oscillator. The block goes directly into the settling window with the oscillator running. Every register keeps its contents through standby. Only the two request bits clear themselves, and they do so when the block returns to normal running.

Top module: `standby_pwr_ctrl`

## Requirements
- R1: After synchronous reset the block is in normal running (pwrState 0), cpuClkEn and oscEn are 1, clkSwitchBusy is 0 and clkSel is 0, which is the slowest rate.
- R2: Bit 3 of regWrData requests deep standby, bit 2 requests light standby and bits 1:0 are the clock select. If bits 3 and 2 are written together, deep standby wins. pwrState codes are 0 normal, 1 light standby, 2 deep standby and 3 settling. cpuClkEn is high only in code 0, and oscEn is low only in code 2.
- R3: A light request is written at clock edge k while no wake source is present and no switch is busy. pwrState then becomes 1 at edge k+1.
- R4: In light standby, a request bit whose enable is clear has no effect. Once any source has both request and enable set, pwrState returns to 0 at the next edge, with no settling wait.
- R5: In deep standby a wake source moves pwrState to 3 at the next edge. The processor clock then stays off for exactly 512 cycles before pwrState returns to 0.
- R6: A deep request taken while a wake source is present never reaches code 2. pwrState goes from 0 to 3, oscEn stays 1, and the 512-cycle settling window still runs in full.
- R7: Writing a clock select that differs from the pending one raises clkSwitchBusy for exactly SWITCH_WAIT cycles. clkSel takes the new value at the same edge on which clkSwitchBusy falls. Writing the same select raises no busy.
- R8: A standby request made while clkSwitchBusy is high is held in normal running. It takes effect at the edge after busy has fallen.
- R9: The request bits clear on return to normal running, so the block stays in code 0 afterwards. The clock select is retained across standby.
- R10: Register writes made while pwrState is not 0 are ignored: they change neither the clock select nor the busy flag.
- R11: A light request made while a wake source is present enters code 1 and leaves it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Write strobe for the clock control word |
| regWrData | input | 4 | Clock control word: deep request, light request, clock select |
| irqReq | input | NUM_IRQ | Interrupt request flags |
| irqEn | input | NUM_IRQ | Interrupt enable flags |
| cpuClkEn | output | 1 | Processor clock enable |
| oscEn | output | 1 | Oscillator enable |
| clkSwitchBusy | output | 1 | Clock select change in progress |
| clkSel | output | 2 | Applied clock select |
| pwrState | output | 2 | Current power state code |

## Verification
A write captured at edge k shows its register effects (pending request, busy flag) right after edge k. A resulting state change appears one edge later, at k+1. The bench therefore drives inputs on the falling edge and samples one and two falling edges after a write. A wake input set before edge j is expected to change pwrState right after edge j.

Durations are measured by counting the falling-edge samples at which a condition holds. That count is compared with SWITCH_WAIT for the busy flag and with 512 for the settling window. Held requests are checked by confirming pwrState stays 0 on every busy sample and turns 1 on the sample after busy drops.

// File: rtl/standby_pkg.sv
package standby_pkg;

  typedef enum logic [1:0] {
    PS_NORMAL = 2'd0,
    PS_HALT   = 2'd1,
    PS_STOP   = 2'd2,
    PS_SETTLE = 2'd3
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrOk;
    logic clrReq;
    logic loadSettle;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic stopReq;
    logic haltReq;
    logic swBusy;
    logic settleDone;
  } dpStatus_t;

endpackage

// File: rtl/standby_datapath.sv
module standby_datapath
  import standby_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int SWITCH_WAIT = 4,
  parameter int SETTLE_LOG2 = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWrEn,
  input  logic [SEL_W+1:0] regWrData,
  input  ctlStrobe_t       strb,
  output dpStatus_t        stat,
  output logic [SEL_W-1:0] clkSel
);

  localparam int STOP_BIT   = SEL_W + 1;
  localparam int HALT_BIT   = SEL_W;
  localparam int SW_CW      = (SWITCH_WAIT > 0) ? $clog2(SWITCH_WAIT + 1) : 1;
  localparam int ST_CW      = SETTLE_LOG2;
  localparam logic [ST_CW-1:0] SETTLE_MAX = {ST_CW{1'b1}};

  logic             stopReq;
  logic             haltReq;
  logic [SEL_W-1:0] selPend;
  logic [SEL_W-1:0] selAct;
  logic [ST_CW-1:0] settleCnt;
  logic             swBusy;
  logic             wrTake;
  logic             selChange;

  assign wrTake    = regWrEn && strb.wrOk;
  assign selChange = wrTake && (regWrData[SEL_W-1:0] != selPend);

  // standby request bits, deep wins over light
  always_ff @(posedge clk) begin
    if (rst) begin
      stopReq <= 1'b0;
      haltReq <= 1'b0;
    end else if (strb.clrReq) begin
      stopReq <= 1'b0;
      haltReq <= 1'b0;
    end else if (wrTake) begin
      if (regWrData[STOP_BIT]) begin
        stopReq <= 1'b1;
      end else if (regWrData[HALT_BIT]) begin
        haltReq <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selPend <= '0;
    end else if (selChange) begin
      selPend <= regWrData[SEL_W-1:0];
    end
  end

  generate
    if (SWITCH_WAIT == 0) begin : g_noWait
      always_ff @(posedge clk) begin
        if (rst) begin
          selAct <= '0;
        end else if (selChange) begin
          selAct <= regWrData[SEL_W-1:0];
        end
      end
      assign swBusy = 1'b0;
    end else begin : g_wait
      logic [SW_CW-1:0] swCnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          swCnt  <= '0;
          selAct <= '0;
        end else if (selChange) begin
          swCnt <= SW_CW'(SWITCH_WAIT);
        end else if (swCnt != '0) begin
          swCnt <= swCnt - 1'b1;
          if (swCnt == SW_CW'(1)) begin
            selAct <= selPend;
          end
        end
      end
      assign swBusy = (swCnt != '0);

      p_sel_applied_r7 : assert property (@(posedge clk) disable iff (rst)
        (swCnt == SW_CW'(1) && !selChange) |=> (selAct == $past(selPend)));
    end
  endgenerate

  // oscillator settling counter
  always_ff @(posedge clk) begin
    if (rst) begin
      settleCnt <= '0;
    end else if (strb.loadSettle) begin
      settleCnt <= SETTLE_MAX;
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  assign stat.stopReq    = stopReq;
  assign stat.haltReq    = haltReq;
  assign stat.swBusy     = swBusy;
  assign stat.settleDone = (settleCnt == '0);
  assign clkSel          = selAct;

  p_settle_count_r5 : assert property (@(posedge clk) disable iff (rst)
    (settleCnt != '0 && !strb.loadSettle) |=> (settleCnt == $past(settleCnt) - 1'b1));

  p_req_hold_r10 : assert property (@(posedge clk) disable iff (rst)
    (!strb.wrOk && !strb.clrReq) |=> ($stable(stopReq) && $stable(haltReq) && $stable(selPend)));

endmodule

// File: rtl/standby_control.sv
module standby_control
  import standby_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  dpStatus_t          stat,
  output ctlStrobe_t         strb,
  output pwrState_e          state
);

  pwrState_e stateNext;
  logic      irqPend;

  assign irqPend = |(irqReq & irqEn);

  always_comb begin
    stateNext       = state;
    strb.wrOk       = (state == PS_NORMAL);
    strb.clrReq     = 1'b0;
    strb.loadSettle = 1'b0;
    unique case (state)
      PS_NORMAL: begin
        if (!stat.swBusy) begin
          if (stat.stopReq) begin
            if (irqPend) begin
              stateNext       = PS_SETTLE;
              strb.loadSettle = 1'b1;
            end else begin
              stateNext = PS_STOP;
            end
          end else if (stat.haltReq) begin
            stateNext = PS_HALT;
          end
        end
      end
      PS_HALT: begin
        if (irqPend) begin
          stateNext   = PS_NORMAL;
          strb.clrReq = 1'b1;
        end
      end
      PS_STOP: begin
        if (irqPend) begin
          stateNext       = PS_SETTLE;
          strb.loadSettle = 1'b1;
        end
      end
      PS_SETTLE: begin
        if (stat.settleDone) begin
          stateNext   = PS_NORMAL;
          strb.clrReq = 1'b1;
        end
      end
      default: stateNext = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_NORMAL;
    end else begin
      state <= stateNext;
    end
  end

  p_halt_wake_r4 : assert property (@(posedge clk) disable iff (rst)
    (state == PS_HALT && irqPend) |=> (state == PS_NORMAL));

  p_stop_wake_r5 : assert property (@(posedge clk) disable iff (rst)
    (state == PS_STOP && irqPend) |=> (state == PS_SETTLE));

  p_settle_hold_r5 : assert property (@(posedge clk) disable iff (rst)
    (state == PS_SETTLE && !stat.settleDone) |=> (state == PS_SETTLE));

  p_skip_stop_r6 : assert property (@(posedge clk) disable iff (rst)
    (state == PS_NORMAL && !stat.swBusy && stat.stopReq && irqPend) |=> (state == PS_SETTLE));

  p_busy_hold_r8 : assert property (@(posedge clk) disable iff (rst)
    (state == PS_NORMAL && stat.swBusy) |=> (state == PS_NORMAL));

endmodule

// File: rtl/standby_pwr_ctrl.sv
module standby_pwr_ctrl
  import standby_pkg::*;
#(
  parameter int NUM_IRQ     = 4,
  parameter int SEL_W       = 2,
  parameter int SWITCH_WAIT = 4,
  parameter int SETTLE_LOG2 = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               regWrEn,
  input  logic [SEL_W+1:0]   regWrData,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEn,
  output logic               cpuClkEn,
  output logic               oscEn,
  output logic               clkSwitchBusy,
  output logic [SEL_W-1:0]   clkSel,
  output logic [1:0]         pwrState
);

  ctlStrobe_t strb;
  dpStatus_t  stat;
  pwrState_e  state;

  standby_control #(
    .NUM_IRQ(NUM_IRQ)
  ) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .irqReq(irqReq),
    .irqEn (irqEn),
    .stat  (stat),
    .strb  (strb),
    .state (state)
  );

  standby_datapath #(
    .SEL_W      (SEL_W),
    .SWITCH_WAIT(SWITCH_WAIT),
    .SETTLE_LOG2(SETTLE_LOG2)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strb     (strb),
    .stat     (stat),
    .clkSel   (clkSel)
  );

  assign cpuClkEn      = (state == PS_NORMAL);
  assign oscEn         = (state != PS_STOP);
  assign clkSwitchBusy = stat.swBusy;
  assign pwrState      = state;

endmodule

// File: tb/standby_pwr_ctrl_tb.sv
module standby_pwr_ctrl_tb;

  localparam int NIRQ   = 4;
  localparam int SW     = 4;
  localparam int SETTLE = 512;

  logic            clk = 1'b0;
  logic            rst;
  logic            regWrEn;
  logic [3:0]      regWrData;
  logic [NIRQ-1:0] irqReq;
  logic [NIRQ-1:0] irqEn;
  logic            cpuClkEn;
  logic            oscEn;
  logic            clkSwitchBusy;
  logic [1:0]      clkSel;
  logic [1:0]      pwrState;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  standby_pwr_ctrl #(
    .NUM_IRQ(NIRQ), .SEL_W(2), .SWITCH_WAIT(SW), .SETTLE_LOG2(9)
  ) u_dut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regWrData(regWrData),
    .irqReq(irqReq), .irqEn(irqEn), .cpuClkEn(cpuClkEn), .oscEn(oscEn),
    .clkSwitchBusy(clkSwitchBusy), .clkSel(clkSel), .pwrState(pwrState)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] v);
    regWrEn   = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int n;
    int lowSeen;
    int held;
    rst = 1'b1; regWrEn = 1'b0; regWrData = '0; irqReq = '0; irqEn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pwrState", pwrState, 0);
    chk("R1 cpuClkEn", cpuClkEn, 1);
    chk("R1 oscEn", oscEn, 1);
    chk("R1 busy", clkSwitchBusy, 0);
    chk("R1 clkSel", clkSel, 0);

    // R7 sweep over every select pair
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        wr(4'(f));
        while (clkSwitchBusy) tick();
        wr(4'(t));
        chk("R7 old select held", clkSel, f);
        n = 0;
        while (clkSwitchBusy && n < 100) begin n++; tick(); end
        chk("R7 busy length", n, (t != f) ? SW : 0);
        chk("R7 select applied", clkSel, t);
      end
    end
    // clkSel is now 3

    // R3 / R4 light standby per interrupt source
    irqEn = '1;
    for (int i = 0; i < NIRQ; i++) begin
      wr(4'b0111);
      chk("R3 still normal", pwrState, 0);
      tick();
      chk("R3 light state", pwrState, 1);
      chk("R3 cpuClkEn off", cpuClkEn, 0);
      chk("R3 oscEn on", oscEn, 1);
      irqEn  = ~(NIRQ'(1) << i);
      irqReq = NIRQ'(1) << i;
      repeat (3) tick();
      chk("R4 disabled source ignored", pwrState, 1);
      irqEn = '1;
      tick();
      chk("R4 wake to normal", pwrState, 0);
      chk("R4 cpuClkEn on", cpuClkEn, 1);
      irqReq = '0;
      repeat (2) tick();
      chk("R9 request cleared", pwrState, 0);
    end

    // R5 deep standby with R10 ignored write
    wr(4'b1011);
    chk("R5 still normal", pwrState, 0);
    tick();
    chk("R5 deep state", pwrState, 2);
    chk("R5 oscEn off", oscEn, 0);
    chk("R5 cpuClkEn off", cpuClkEn, 0);
    regWrEn = 1'b1; regWrData = 4'b0100;
    tick();
    regWrEn = 1'b0;
    chk("R10 busy unchanged", clkSwitchBusy, 0);
    chk("R10 select unchanged", clkSel, 3);
    irqReq = 4'b0001;
    tick();
    chk("R5 settling state", pwrState, 3);
    chk("R5 oscEn back on", oscEn, 1);
    irqReq = '0;
    n = 0;
    while (pwrState == 2'd3 && n < 2000) begin
      if (cpuClkEn) n += 10000;
      n++; tick();
    end
    chk("R5 settle length", n, SETTLE);
    chk("R5 back to normal", pwrState, 0);
    repeat (3) tick();
    chk("R10 no light entry", pwrState, 0);
    chk("R9 select retained", clkSel, 3);

    // R6 deep request with wake pending
    irqReq = 4'b0010;
    wr(4'b1011);
    chk("R6 still normal", pwrState, 0);
    tick();
    chk("R6 direct to settling", pwrState, 3);
    n = 0; lowSeen = 0;
    while (pwrState == 2'd3 && n < 2000) begin
      if (!oscEn) lowSeen++;
      n++; tick();
    end
    chk("R6 settle length", n, SETTLE);
    chk("R6 oscEn never low", lowSeen, 0);
    tick();
    chk("R9 no re-entry", pwrState, 0);
    irqReq = '0;

    // R11 light request with wake pending
    irqReq = 4'b1000;
    wr(4'b0111);
    chk("R11 still normal", pwrState, 0);
    tick();
    chk("R11 light entered", pwrState, 1);
    tick();
    chk("R11 light left", pwrState, 0);
    irqReq = '0;

    // R2 both request bits: deep wins
    wr(4'b1111);
    tick();
    chk("R2 deep priority", pwrState, 2);
    irqReq = 4'b0100;
    tick();
    chk("R2 settling code", pwrState, 3);
    irqReq = '0;
    n = 0;
    while (pwrState != 2'd0 && n < 2000) begin n++; tick(); end

    // R8 request held during clock switch
    wr(4'b0101);
    n = 0; held = 1;
    while (clkSwitchBusy && n < 100) begin
      if (pwrState != 2'd0) held = 0;
      n++; tick();
    end
    chk("R8 busy length", n, SW);
    chk("R8 held while busy", held, 1);
    chk("R8 normal at busy fall", pwrState, 0);
    chk("R8 new select", clkSel, 1);
    tick();
    chk("R8 light after busy", pwrState, 1);
    irqReq = 4'b0001;
    tick();
    chk("R4 wake after held", pwrState, 0);
    irqReq = '0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule